// File: doc/BRIEF.md
# FIFO Flag Controller with Standard and Fall-Through Timing

This block is a single-clock FIFO controller built around a register array of `DEPTH` words. It produces five status outputs: empty (or output-ready), full (or input-ready), half-full, almost-empty and almost-full. All of them are active LOW. The almost-empty offset `n` and the almost-full offset `m` arrive as plain inputs, so the surrounding logic can change them at any time.

A master reset clears the block and captures two mode bits. The first chooses between standard timing and fall-through timing:
- **Standard timing:** every word, the first included, needs an explicit read.
- **Fall-through timing:** the first word written into an empty FIFO moves to the output register by itself. That register then counts as one extra word of storage, so every threshold moves up by one.

The second mode bit chooses between two retransmit latencies. Retransmit rewinds the read side to location zero so that the data held there can be read again. A partial reset clears the data path but keeps both captured mode bits.

The read side is a two-state machine:
- **`ST_RUN`** is the normal state.
- **`ST_RT_WAIT`** is the one-cycle recovery state of normal-latency retransmit.

Its transitions are:
- **`RUN->RUN`:** ordinary traffic, or a zero-latency retransmit.
- **`RUN->RT_WAIT`:** a normal-latency retransmit request.
- **`RT_WAIT->RUN`:** always taken on the next edge, where the occupancy is restored.
- **`any->RUN`:** a partial or master reset.

Top module: `fifo_flag_ctrl`

## Requirements
Occupancy means the words held in the array. In fall-through mode it also counts the word in the output register while that word is valid. All outputs change on the clock edge that causes the change.

- R1: In standard mode, an edge with `rd_en` HIGH and a non-zero occupancy places the oldest word on `rd_data`. Otherwise `rd_data` holds its value.
- R2: In fall-through mode, a word written into an empty FIFO appears on `rd_data` one edge after the write edge, without `rd_en`. An edge with `rd_en` HIGH consumes the shown word and shows the next one, if there is one.
- R3: `ef_or_n` is LOW when the occupancy is zero (standard mode), or when `rd_data` holds a valid word (fall-through mode).
- R4: `ff_ir_n` is LOW when the occupancy equals DEPTH (standard mode). In fall-through mode it is LOW while the occupancy is below DEPTH+1.
- R5: `pae_n` is LOW while the occupancy is at most `n` (standard mode) or at most `n+1` (fall-through mode).
- R6: `hf_n` is LOW while the occupancy exceeds DEPTH/2 (standard mode) or DEPTH/2+1 (fall-through mode).
- R7: `paf_n` is LOW while the occupancy is at least DEPTH−`m` (standard mode) or DEPTH+1−`m` (fall-through mode).
- R8: A write at full capacity is dropped unless a read is taken on the same edge. A read at zero occupancy is ignored. A read and a write on one edge, away from both limits, leave the occupancy unchanged.
- R9: With normal latency (`rt_lat_sel` HIGH at master reset), an edge with `rt_req` HIGH ignores that edge's read and write, rewinds the read side to location 0 and shows the FIFO as empty. On the next edge the occupancy becomes the count of words written since the last reset, plus any write on that edge.
- R10: With zero latency (`rt_lat_sel` LOW at master reset), the `rt_req` edge places the word at location 0 on `rd_data` directly. The remaining written words stay readable. This holds only if at least one word was written since the last reset.
- R11: A partial reset (`prst_n` LOW at an edge) sets the occupancy to zero and `rd_data` to zero, and keeps both captured mode bits.
- R12: A master reset (`mrst_n` LOW) clears everything at once. While it is LOW, each edge captures the mode bits: `cfg_fwft` HIGH selects fall-through timing, and `rt_lat_sel` LOW selects zero-latency retransmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active LOW, asynchronous assert |
| prst_n | input | 1 | Partial reset, active LOW, synchronous |
| cfg_fwft | input | 1 | Timing mode, captured during master reset |
| rt_lat_sel | input | 1 | Retransmit latency, captured during master reset (LOW = zero latency) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Retransmit request |
| off_empty | input | CW | Almost-empty offset n |
| off_full | input | CW | Almost-full offset m |
| rd_data | output | WIDTH | Output register |
| ef_or_n | output | 1 | Empty (standard) / output-ready (fall-through), active LOW |
| ff_ir_n | output | 1 | Full (standard) / input-ready (fall-through), active LOW |
| hf_n | output | 1 | Half-full, active LOW |
| pae_n | output | 1 | Almost-empty, active LOW |
| paf_n | output | 1 | Almost-full, active LOW |

## Verification
The bench builds the block with DEPTH 8 and WIDTH 12. A shallow array lets each pass fill past capacity, sit at the half-full and almost-full thresholds, and drain past empty within a few dozen cycles. All four combinations of timing mode and retransmit latency are run after a master reset each. In every pass both offsets are drawn at random over the range 0 to DEPTH, so offsets of zero and of the full depth are both reachable. Retransmit is issued only while fewer than DEPTH words have been written since the last reset, which keeps the rewound contents well defined.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RT_WAIT = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic fwft;
        logic rt_zero;
    } mode_t;

endpackage

// File: rtl/ffc_store.sv
module ffc_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ffc_outreg.sv
module ffc_outreg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/ffc_ctrl.sv
module ffc_ctrl
    import ffc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 6,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  mode_t         mode,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rt_req,
    output logic          wr_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          out_load,
    output logic          out_clear,
    output logic [CW-1:0] cnt,
    output logic          ov
);

    rd_state_e     st, st_nx;
    logic [AW-1:0] wp, wp_nx, rp, rp_nx;
    logic [CW-1:0] cnt_nx;
    logic          ov_nx;
    logic          pop, drop_ov;

    // Next-state and datapath control.
    always_comb begin
        st_nx     = st;
        wp_nx     = wp;
        rp_nx     = rp;
        cnt_nx    = cnt;
        ov_nx     = ov;
        pop       = 1'b0;
        drop_ov   = 1'b0;
        wr_ok     = 1'b0;
        out_load  = 1'b0;
        out_clear = 1'b0;
        raddr     = rp;

        if (!prst_n) begin
            st_nx     = ST_RUN;
            wp_nx     = '0;
            rp_nx     = '0;
            cnt_nx    = '0;
            ov_nx     = 1'b0;
            out_clear = 1'b1;
        end else if (rt_req) begin
            rp_nx  = '0;
            cnt_nx = '0;
            ov_nx  = 1'b0;
            if (mode.rt_zero) begin
                st_nx = ST_RUN;
                if (wp != '0) begin
                    raddr    = '0;
                    out_load = 1'b1;
                    rp_nx    = AW'(1);
                    cnt_nx   = CW'(wp) - CW'(1);
                    ov_nx    = mode.fwft;
                end
            end else begin
                st_nx = ST_RT_WAIT;
            end
        end else begin
            unique case (st)
                ST_RT_WAIT: begin
                    wr_ok  = wr_en;
                    cnt_nx = CW'(wp) + CW'(wr_en);
                    st_nx  = ST_RUN;
                end
                ST_RUN: begin
                    if (mode.fwft) begin
                        pop     = (cnt != '0) && (!ov || rd_en);
                        drop_ov = rd_en && ov && (cnt == '0);
                    end else begin
                        pop     = rd_en && (cnt != '0);
                    end
                    wr_ok    = wr_en && ((cnt < CW'(DEPTH)) || pop);
                    out_load = pop;
                    if (pop) begin
                        rp_nx = rp + AW'(1);
                        ov_nx = mode.fwft;
                    end else if (drop_ov) begin
                        ov_nx = 1'b0;
                    end
                    cnt_nx = cnt - CW'(pop) + CW'(wr_ok);
                end
                default: st_nx = ST_RUN;
            endcase
        end

        if (wr_ok) begin
            wp_nx = wp + AW'(1);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge mrst_n) begin
        if (!mrst_n) begin
            st  <= ST_RUN;
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ov  <= 1'b0;
        end else begin
            st  <= st_nx;
            wp  <= wp_nx;
            rp  <= rp_nx;
            cnt <= cnt_nx;
            ov  <= ov_nx;
        end
    end

    assign waddr = wp;

    // R8: occupancy of the array never passes its depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!mrst_n)
        cnt <= CW'(DEPTH));

    // R8: write at full without a read leaves the write side untouched
    a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !rt_req && st == ST_RUN && !mode.fwft && cnt == CW'(DEPTH)
         && wr_en && !rd_en) |=> (cnt == CW'(DEPTH)) && $stable(wp));

    // R8: read at zero occupancy is ignored
    a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && !rt_req && st == ST_RUN && !mode.fwft && cnt == '0
         && rd_en && !wr_en) |=> (cnt == '0) && $stable(rp));

    // R9: normal-latency retransmit shows empty and waits one cycle
    a_r9_rt_normal_wait: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && rt_req && !mode.rt_zero) |=>
            (st == ST_RT_WAIT) && (cnt == '0) && (rp == '0) && $stable(wp));

    // R10: zero-latency retransmit consumes location 0 on the same edge
    a_r10_rt_zero_step: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && rt_req && mode.rt_zero && wp != '0) |=>
            (rp == AW'(1)) && (st == ST_RUN) && $stable(wp));

    // R11: partial reset empties the controller
    a_r11_prst_clears: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (cnt == '0) && (wp == '0) && (rp == '0) && !ov);

endmodule

// File: rtl/ffc_flags.sv
module ffc_flags #(
    parameter int DEPTH = 16,
    parameter int CW    = 6
) (
    input  logic          fwft,
    input  logic [CW-1:0] cnt,
    input  logic          ov,
    input  logic [CW-1:0] off_empty,
    input  logic [CW-1:0] off_full,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);

    localparam int TW = CW + 2;

    logic [TW-1:0] occ, shift, n_e, m_f;

    always_comb begin
        shift = TW'(fwft);
        occ   = TW'(cnt) + TW'(fwft & ov);
        n_e   = TW'(off_empty);
        m_f   = TW'(off_full);

        ef_or_n = fwft ? ~ov : (cnt != '0);
        ff_ir_n = fwft ? (occ == TW'(DEPTH + 1)) : (cnt != CW'(DEPTH));
        pae_n   = occ > (n_e + shift);
        hf_n    = ~(occ > (TW'(DEPTH / 2) + shift));
        paf_n   = ~((occ + m_f) >= (TW'(DEPTH) + shift));
    end

endmodule

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
    import ffc_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(2 * DEPTH + 2)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             cfg_fwft,
    input  logic             rt_lat_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rt_req,
    input  logic [CW-1:0]    off_empty,
    input  logic [CW-1:0]    off_full,
    output logic [WIDTH-1:0] rd_data,
    output logic             ef_or_n,
    output logic             ff_ir_n,
    output logic             hf_n,
    output logic             pae_n,
    output logic             paf_n
);

    mode_t            mode;
    logic             wr_ok, out_load, out_clear, ov;
    logic [AW-1:0]    waddr, raddr;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] rdata;

    // Mode bits follow the configuration pins while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode.fwft    <= cfg_fwft;
            mode.rt_zero <= ~rt_lat_sel;
        end
    end

    ffc_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    ffc_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .mode      (mode),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rt_req    (rt_req),
        .wr_ok     (wr_ok),
        .waddr     (waddr),
        .raddr     (raddr),
        .out_load  (out_load),
        .out_clear (out_clear),
        .cnt       (cnt),
        .ov        (ov)
    );

    ffc_outreg #(.WIDTH(WIDTH)) u_out (
        .clk    (clk),
        .mrst_n (mrst_n),
        .clear  (out_clear),
        .load   (out_load),
        .din    (rdata),
        .q      (rd_data)
    );

    ffc_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .fwft      (mode.fwft),
        .cnt       (cnt),
        .ov        (ov),
        .off_empty (off_empty),
        .off_full  (off_full),
        .ef_or_n   (ef_or_n),
        .ff_ir_n   (ff_ir_n),
        .hf_n      (hf_n),
        .pae_n     (pae_n),
        .paf_n     (paf_n)
    );

    // R3/R4: in standard mode the block is never full and empty at once
    a_r4_full_excl_empty: assert property (@(posedge clk) disable iff (!mrst_n)
        !mode.fwft |-> !(!ff_ir_n && !ef_or_n));

    // R11: partial reset keeps the captured mode bits
    a_r11_mode_kept: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> $stable(mode));

    // R11: partial reset zeroes the output register
    a_r11_out_zero: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (rd_data == '0));

    // R1: in standard mode the output holds when no read is taken
    a_r1_hold_no_read: assert property (@(posedge clk) disable iff (!mrst_n)
        (!mode.fwft && prst_n && !rt_req && !rd_en) |=> $stable(rd_data));

endmodule

// File: tb/sim_fifo_flag_ctrl.sv
module sim_fifo_flag_ctrl;

    localparam int D  = 8;
    localparam int W  = 12;
    localparam int CW = $clog2(2 * D + 2);

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          cfg_fwft = 1'b0, rt_lat_sel = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [CW-1:0] off_empty = '0, off_full = '0;
    logic [W-1:0]  rd_data;
    logic          ef_or_n, ff_ir_n, hf_n, pae_n, paf_n;

    int    checks = 0;
    int    errors = 0;
    string phase  = "init";

    // Reference state derived from the requirements.
    bit          m_fwft, m_rtz, m_wait;
    int          m_cnt, m_ov, m_wp, m_rp, m_tot;
    logic [W-1:0] m_mem [D];
    logic [W-1:0] m_dout;

    always #2 clk = ~clk;

    fifo_flag_ctrl #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_fwft(cfg_fwft),
        .rt_lat_sel(rt_lat_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rt_req(rt_req), .off_empty(off_empty), .off_full(off_full),
        .rd_data(rd_data), .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n), .hf_n(hf_n),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    task automatic m_clear();
        m_cnt = 0; m_ov = 0; m_wp = 0; m_rp = 0; m_tot = 0;
        m_wait = 1'b0; m_dout = '0;
    endtask

    task automatic m_write();
        m_mem[m_wp] = wr_data;
        m_wp = (m_wp + 1) % D;
        m_tot++;
    endtask

    task automatic edge_model();
        bit pop, wr;
        int old_wp;
        if (!mrst_n) begin
            m_fwft = cfg_fwft;
            m_rtz  = !rt_lat_sel;
            m_clear();
        end else if (!prst_n) begin
            m_clear();
        end else if (rt_req) begin
            m_rp = 0; m_cnt = 0; m_ov = 0;
            if (m_rtz) begin
                if (m_wp != 0) begin
                    m_dout = m_mem[0];
                    m_rp = 1; m_cnt = m_wp - 1; m_ov = m_fwft;
                end
            end else begin
                m_wait = 1'b1;
            end
        end else if (m_wait) begin
            m_wait = 1'b0;
            old_wp = m_wp;
            if (wr_en) m_write();
            m_cnt = old_wp + (wr_en ? 1 : 0);
        end else begin
            if (m_fwft) pop = (m_cnt > 0) && (m_ov == 0 || rd_en);
            else        pop = rd_en && (m_cnt > 0);
            wr = wr_en && (m_cnt < D || pop);
            if (pop) begin
                m_dout = m_mem[m_rp];
                m_rp = (m_rp + 1) % D;
                m_ov = m_fwft;
            end else if (m_fwft && rd_en && m_ov == 1 && m_cnt == 0) begin
                m_ov = 0;
            end
            if (wr) m_write();
            m_cnt = m_cnt - (pop ? 1 : 0) + (wr ? 1 : 0);
        end
    endtask

    task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s phase=%s actual=%0h expected=%0h", req, what, phase, act, exp);
        end
    endtask

    task automatic check_all();
        int occ, k;
        bit e_ef, e_ff, e_hf, e_pae, e_paf;
        k   = m_fwft ? 1 : 0;
        occ = m_cnt + (m_fwft ? m_ov : 0);
        e_ef  = m_fwft ? (m_ov == 0) : (m_cnt != 0);
        e_ff  = m_fwft ? (occ == D + 1) : (m_cnt != D);
        e_pae = occ > int'(off_empty) + k;
        e_hf  = !(occ > D / 2 + k);
        e_paf = !(occ + int'(off_full) >= D + k);
        cmp(m_fwft ? "R2" : "R1", "rd_data", rd_data, m_dout);
        cmp("R3", "ef_or_n", W'(ef_or_n), W'(e_ef));
        cmp("R4", "ff_ir_n", W'(ff_ir_n), W'(e_ff));
        cmp("R5", "pae_n",   W'(pae_n),   W'(e_pae));
        cmp("R6", "hf_n",    W'(hf_n),    W'(e_hf));
        cmp("R7", "paf_n",   W'(paf_n),   W'(e_paf));
    endtask

    task automatic step();
        @(posedge clk);
        edge_model();
        #1;
        check_all();
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_en = 1'b0; rt_req = 1'b0; prst_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired phase=%s", phase);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int md = 0; md < 4; md++) begin
            // R12: master reset captures the mode bits
            phase = "R12_reset";
            idle();
            cfg_fwft   = md[0];
            rt_lat_sel = md[1];
            mrst_n = 1'b0;
            step();
            step();
            mrst_n = 1'b1;
            cfg_fwft = ~cfg_fwft;
            rt_lat_sel = ~rt_lat_sel;
            off_empty = CW'($urandom_range(0, D));
            off_full  = CW'($urandom_range(0, D));
            step();

            // R8: fill past capacity; extra writes are dropped
            phase = "R8_fill";
            for (int i = 0; i < D + 3; i++) begin
                wr_en = 1'b1;
                wr_data = W'($urandom);
                step();
            end
            phase = "R8_rw_at_full";
            rd_en = 1'b1;
            wr_data = W'($urandom);
            step();
            // R8: drain past empty; extra reads are ignored
            phase = "R8_drain";
            wr_en = 1'b0;
            for (int i = 0; i < D + 4; i++) step();
            idle();
            step();

            // R11: partial reset keeps the mode
            phase = "R11_partial";
            wr_en = 1'b1; wr_data = W'($urandom);
            step();
            prst_n = 1'b0; wr_en = 1'b0;
            step();
            prst_n = 1'b1;
            step();

            // R9 / R10: retransmit after a few writes and reads
            phase = md[1] ? "R9_rt_normal" : "R10_rt_zero";
            for (int i = 0; i < 5; i++) begin
                wr_en = 1'b1; wr_data = W'($urandom);
                step();
            end
            wr_en = 1'b0; rd_en = 1'b1;
            step();
            step();
            rd_en = 1'b0; rt_req = 1'b1;
            step();
            rt_req = 1'b0;
            step();
            rd_en = 1'b1;
            for (int i = 0; i < 7; i++) step();
            idle();

            // Constrained random traffic with occasional resets and retransmits
            phase = "random";
            for (int i = 0; i < 500; i++) begin
                wr_en   = ($urandom_range(0, 99) < 55);
                rd_en   = ($urandom_range(0, 99) < 45);
                wr_data = W'($urandom);
                prst_n  = !($urandom_range(0, 63) == 0);
                rt_req  = (m_tot < D) && ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 49) == 0) begin
                    off_empty = CW'($urandom_range(0, D));
                    off_full  = CW'($urandom_range(0, D));
                end
                step();
            end
            idle();
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule